// File: doc/BRIEF.md
# DSP Data Address Generator

This block forms the 16-bit data-memory address for each operand access of a DSP core. A direct access concatenates a 9-bit page register, which supplies the upper address bits, with a 7-bit offset carried in the instruction. Each page therefore covers 128 words, and 512 pages span the full space. An indirect access instead uses the contents of the currently selected one of eight 16-bit auxiliary registers. That register can be updated after it has been used: by one, by the index held in register 0, or by that index with the carry running from the top bit toward the bottom. The last option steps a pointer through bit-reversed order, as radix-2 FFT code needs.

The same indirect access can name the register that becomes current for the following instructions. Separate ports load the page register, load the register pointer with an immediate, load any auxiliary register, and read any auxiliary register out for storing. The address is combinational from the current state and the access inputs. All state changes on the rising clock edge. Every port is a plain control or data pin. Each access completes in one cycle and cannot be stalled, so there is no valid/ready pairing and no back-pressure.

Top module: `dag_top`

## Requirements
- R1: After reset, the page register, the register pointer and all eight auxiliary registers read zero, and `addr` is 0 in direct mode with a zero offset.
- R2: When `acc_indirect` is 0, `addr` equals the page in bits 15:7 and `offset` in bits 6:0, in the same cycle.
- R3: `page_ld` replaces only the page register at the next edge. The pointer and the auxiliary registers keep their values.
- R4: When `acc_indirect` is 1, `addr` equals the current auxiliary register's value before any modification of this access, in the same cycle.
- R5: On an edge where `acc_en` and `acc_indirect` are both 1, the current register is rewritten according to `mod_op`, modulo 2^16: 0 leaves it unchanged, 1 adds 1, 2 subtracts 1, 3 adds AR0, 4 subtracts AR0, and 7 leaves it unchanged.
- R6: `mod_op` 5 adds AR0 and 6 subtracts AR0 with the carry reversed. The result equals rev(rev(AR) + rev(AR0)) or rev(rev(AR) - rev(AR0)), where rev mirrors the 16 bits.
- R7: When the current register is AR0 and it is modified by the index (codes 3 to 6), the value of AR0 before the edge serves as the index.
- R8: During an indirect access with `nxt_ptr_en` set, `nxt_ptr` becomes the current pointer after the edge. The address of that access still uses the old pointer.
- R9: `ptr_ld` loads `ptr_val` into the pointer at the next edge and takes priority over `nxt_ptr`.
- R10: `ar_ld` writes `ar_ld_val` into the register selected by `ar_ld_sel`. If that register is also being modified in the same cycle, the load wins.
- R11: `ar_rd_val` shows the register selected by `ar_rd_sel` combinationally.
- R12: When `acc_en` is 0, or the access is direct, `mod_op` and `nxt_ptr_en` have no effect on the registers or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_ld | input | 1 | Load the page register |
| page_val | input | 9 | New page value |
| ptr_ld | input | 1 | Load the register pointer with an immediate |
| ptr_val | input | 3 | Immediate pointer value |
| acc_en | input | 1 | An operand access takes place this cycle |
| acc_indirect | input | 1 | 1 selects indirect mode, 0 selects direct mode |
| offset | input | 7 | Offset within the page from the instruction |
| mod_op | input | 3 | Post-modify code (see R5, R6) |
| nxt_ptr_en | input | 1 | The instruction names a new current register |
| nxt_ptr | input | 3 | New current register number |
| ar_ld | input | 1 | Load an auxiliary register |
| ar_ld_sel | input | 3 | Register to load |
| ar_ld_val | input | 16 | Value to load |
| ar_rd_sel | input | 3 | Register to read out |
| ar_rd_val | output | 16 | Value of the selected register |
| addr | output | 16 | Effective data address |
| cur_ptr | output | 3 | Current register pointer |
| page | output | 9 | Current page |

## Verification
`addr` and `ar_rd_val` are due in the same cycle as the inputs that select them. Register, pointer and page updates are due one rising edge after the cycle that requests them. The bench drives inputs just after a falling edge and compares the combinational results a nanosecond later, against a model that still holds the state before the edge. It advances the model only at the rising edge, so state-dependent outputs are compared one cycle after their cause. The bit-reversed walk and the self-indexed AR0 case are replayed as fixed sequences with hand-computed expectations.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    MOD_NONE = 3'd0,
    MOD_INC  = 3'd1,
    MOD_DEC  = 3'd2,
    MOD_IADD = 3'd3,
    MOD_ISUB = 3'd4,
    MOD_RADD = 3'd5,
    MOD_RSUB = 3'd6,
    MOD_HOLD = 3'd7
  } mod_op_e;
endpackage

// File: rtl/dag_page_reg.sv
module dag_page_reg #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [PW-1:0] val,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (ld) q <= val;
  end
endmodule

// File: rtl/dag_ptr_reg.sv
module dag_ptr_reg #(
  parameter int PTRW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imm_ld,
  input  logic [PTRW-1:0] imm_val,
  input  logic            upd,
  input  logic [PTRW-1:0] upd_val,
  output logic [PTRW-1:0] q
);
  // The immediate load outranks the pointer named by an access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (imm_ld) q <= imm_val;
    else if (upd) q <= upd_val;
  end
endmodule

// File: rtl/dag_post_mod.sv
module dag_post_mod
  import dag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] idx,
  input  mod_op_e       op,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] cur_m, idx_m, sum_m, dif_m, sum_b, dif_b;

  // Mirror the operands, use an ordinary adder, then mirror back.
  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign cur_m[b] = cur[AW-1-b];
    assign idx_m[b] = idx[AW-1-b];
    assign sum_b[b] = sum_m[AW-1-b];
    assign dif_b[b] = dif_m[AW-1-b];
  end

  assign sum_m = cur_m + idx_m;
  assign dif_m = cur_m - idx_m;

  always_comb begin
    case (op)
      MOD_INC:  nxt = cur + AW'(1);
      MOD_DEC:  nxt = cur - AW'(1);
      MOD_IADD: nxt = cur + idx;
      MOD_ISUB: nxt = cur - idx;
      MOD_RADD: nxt = sum_b;
      MOD_RSUB: nxt = dif_b;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/dag_ar_file.sv
module dag_ar_file #(
  parameter int AW   = 16,
  parameter int NAR  = 8,
  parameter int PTRW = $clog2(NAR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [PTRW-1:0] ld_sel,
  input  logic [AW-1:0]   ld_val,
  input  logic            mod_en,
  input  logic [PTRW-1:0] mod_sel,
  input  logic [AW-1:0]   mod_val,
  input  logic [PTRW-1:0] sel_a,
  output logic [AW-1:0]   val_a,
  input  logic [PTRW-1:0] sel_b,
  output logic [AW-1:0]   val_b,
  output logic [AW-1:0]   idx
);
  logic [AW-1:0] regs [NAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NAR; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NAR; i++) begin
        if (ld_en && ld_sel == PTRW'(i)) regs[i] <= ld_val;
        else if (mod_en && mod_sel == PTRW'(i)) regs[i] <= mod_val;
      end
    end
  end

  assign val_a = regs[sel_a];
  assign val_b = regs[sel_b];
  assign idx   = regs[0];
endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PW  = 9,
  parameter int NAR = 8,
  localparam int OW   = AW - PW,
  localparam int PTRW = $clog2(NAR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            page_ld,
  input  logic [PW-1:0]   page_val,
  input  logic            ptr_ld,
  input  logic [PTRW-1:0] ptr_val,
  input  logic            acc_en,
  input  logic            acc_indirect,
  input  logic [OW-1:0]   offset,
  input  logic [2:0]      mod_op,
  input  logic            nxt_ptr_en,
  input  logic [PTRW-1:0] nxt_ptr,
  input  logic            ar_ld,
  input  logic [PTRW-1:0] ar_ld_sel,
  input  logic [AW-1:0]   ar_ld_val,
  input  logic [PTRW-1:0] ar_rd_sel,
  output logic [AW-1:0]   ar_rd_val,
  output logic [AW-1:0]   addr,
  output logic [PTRW-1:0] cur_ptr,
  output logic [PW-1:0]   page
);
  logic          ind_acc;
  logic [AW-1:0] cur_ar, idx_ar, mod_res;

  assign ind_acc = acc_en && acc_indirect;

  dag_page_reg #(.PW(PW)) u_page (
    .clk(clk), .rst_n(rst_n), .ld(page_ld), .val(page_val), .q(page)
  );

  dag_ptr_reg #(.PTRW(PTRW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .imm_ld(ptr_ld), .imm_val(ptr_val),
    .upd(ind_acc && nxt_ptr_en), .upd_val(nxt_ptr), .q(cur_ptr)
  );

  dag_ar_file #(.AW(AW), .NAR(NAR), .PTRW(PTRW)) u_ars (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ar_ld), .ld_sel(ar_ld_sel), .ld_val(ar_ld_val),
    .mod_en(ind_acc), .mod_sel(cur_ptr), .mod_val(mod_res),
    .sel_a(cur_ptr), .val_a(cur_ar),
    .sel_b(ar_rd_sel), .val_b(ar_rd_val),
    .idx(idx_ar)
  );

  dag_post_mod #(.AW(AW)) u_mod (
    .cur(cur_ar), .idx(idx_ar), .op(mod_op_e'(mod_op)), .nxt(mod_res)
  );

  assign addr = acc_indirect ? cur_ar : {page, offset};
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int AW   = 16,
  parameter int PW   = 9,
  parameter int PTRW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            page_ld,
  input logic [PW-1:0]   page_val,
  input logic            ptr_ld,
  input logic [PTRW-1:0] ptr_val,
  input logic            acc_en,
  input logic            acc_indirect,
  input logic [2:0]      mod_op,
  input logic            nxt_ptr_en,
  input logic [PTRW-1:0] nxt_ptr,
  input logic            ar_ld,
  input logic [PTRW-1:0] ar_ld_sel,
  input logic [PTRW-1:0] cur_ptr,
  input logic [PW-1:0]   page,
  input logic [AW-1:0]   cur_ar
);
  logic quiet_cur;
  assign quiet_cur = !ptr_ld && !nxt_ptr_en && !(ar_ld && ar_ld_sel == cur_ptr);

  // R3
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld |=> page == $past(page_val));

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ld |=> $stable(page));

  // R9
  ptr_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> cur_ptr == $past(ptr_val));

  // R8
  ptr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_indirect && nxt_ptr_en && !ptr_ld) |=> cur_ptr == $past(nxt_ptr));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_indirect && mod_op == 3'd1 && quiet_cur)
      |=> cur_ar == AW'($past(cur_ar) + AW'(1)));

  // R5
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_indirect && mod_op == 3'd0 && quiet_cur) |=> $stable(cur_ar));

  // R7
  self_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_indirect && mod_op == 3'd3 && cur_ptr == '0 && quiet_cur)
      |=> cur_ar == AW'($past(cur_ar) << 1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_en && acc_indirect) && !ptr_ld && !ar_ld) |=> $stable(cur_ar) && $stable(cur_ptr));
endmodule

bind dag_top dag_chk #(.AW(AW), .PW(PW), .PTRW(PTRW)) u_dag_chk (
  .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val),
  .ptr_ld(ptr_ld), .ptr_val(ptr_val), .acc_en(acc_en), .acc_indirect(acc_indirect),
  .mod_op(mod_op), .nxt_ptr_en(nxt_ptr_en), .nxt_ptr(nxt_ptr),
  .ar_ld(ar_ld), .ar_ld_sel(ar_ld_sel), .cur_ptr(cur_ptr), .page(page),
  .cur_ar(cur_ar)
);

// File: tb/tb_dag_top.sv
`timescale 1ns/1ps
module tb_dag_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        page_ld, ptr_ld, acc_en, acc_indirect, nxt_ptr_en, ar_ld;
  logic [8:0]  page_val;
  logic [2:0]  ptr_val, mod_op, nxt_ptr, ar_ld_sel, ar_rd_sel;
  logic [6:0]  offset;
  logic [15:0] ar_ld_val;
  logic [15:0] ar_rd_val, addr;
  logic [2:0]  cur_ptr;
  logic [8:0]  page;

  dag_top dut (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_val(page_val),
    .ptr_ld(ptr_ld), .ptr_val(ptr_val), .acc_en(acc_en), .acc_indirect(acc_indirect),
    .offset(offset), .mod_op(mod_op), .nxt_ptr_en(nxt_ptr_en), .nxt_ptr(nxt_ptr),
    .ar_ld(ar_ld), .ar_ld_sel(ar_ld_sel), .ar_ld_val(ar_ld_val),
    .ar_rd_sel(ar_rd_sel), .ar_rd_val(ar_rd_val), .addr(addr),
    .cur_ptr(cur_ptr), .page(page)
  );

  int nchk = 0;
  int nbad = 0;
  logic [15:0] m_ar [8];
  logic [2:0]  m_ptr;
  logic [8:0]  m_page;

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] post_mod(input logic [15:0] a, input logic [15:0] x,
                                           input logic [2:0] op);
    case (op)
      3'd1: return a + 16'd1;
      3'd2: return a - 16'd1;
      3'd3: return a + x;
      3'd4: return a - x;
      3'd5: return rev16(rev16(a) + rev16(x));
      3'd6: return rev16(rev16(a) - rev16(x));
      default: return a;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    page_ld = 0; page_val = '0; ptr_ld = 0; ptr_val = '0; acc_en = 0;
    acc_indirect = 0; offset = '0; mod_op = '0; nxt_ptr_en = 0; nxt_ptr = '0;
    ar_ld = 0; ar_ld_sel = '0; ar_ld_val = '0; ar_rd_sel = '0;
  endtask

  // Called at a falling edge with inputs set; compares, advances the model one edge.
  task automatic cycle();
    logic [15:0] mv;
    logic [2:0]  op_ptr;
    #1;
    check(acc_indirect ? "R4 addr" : "R2 addr", addr,
          acc_indirect ? m_ar[m_ptr] : {m_page, offset});
    check("R11 read", ar_rd_val, m_ar[ar_rd_sel]);
    check("R9 ptr", {13'd0, cur_ptr}, {13'd0, m_ptr});
    check("R3 page", {7'd0, page}, {7'd0, m_page});
    op_ptr = m_ptr;
    mv = post_mod(m_ar[op_ptr], m_ar[0], mod_op);
    @(posedge clk);
    if (page_ld) m_page = page_val;
    if (acc_en && acc_indirect) m_ar[op_ptr] = mv;
    if (ar_ld) m_ar[ar_ld_sel] = ar_ld_val;
    if (ptr_ld) m_ptr = ptr_val;
    else if (acc_en && acc_indirect && nxt_ptr_en) m_ptr = nxt_ptr;
    @(negedge clk);
  endtask

  task automatic load_ar(input logic [2:0] s, input logic [15:0] v);
    idle(); ar_ld = 1; ar_ld_sel = s; ar_ld_val = v; cycle();
  endtask

  task automatic ind_acc(input logic [2:0] op);
    idle(); acc_en = 1; acc_indirect = 1; mod_op = op; cycle();
  endtask

  initial begin
    #(200000 * 5);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    for (int i = 0; i < 8; i++) m_ar[i] = '0;
    m_ptr = '0; m_page = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state through the read port and the address
    for (int i = 0; i < 8; i++) begin
      idle(); ar_rd_sel = 3'(i); #1;
      check("R1 reset reg", ar_rd_val, 16'h0000);
      @(negedge clk);
    end
    idle(); #1;
    check("R1 reset addr", addr, 16'h0000);
    @(negedge clk);

    // R2/R3: page 6, offset 0 -> 0x0300; offset 1 -> 0x0301
    idle(); page_ld = 1; page_val = 9'd6; cycle();
    idle(); acc_en = 1; offset = 7'd0; #1; check("R2 page6", addr, 16'h0300); @(negedge clk);
    idle(); acc_en = 1; offset = 7'd1; #1; check("R2 page6+1", addr, 16'h0301); @(negedge clk);
    idle(); page_ld = 1; page_val = 9'h1FF; cycle();
    idle(); offset = 7'h7F; #1; check("R2 top", addr, 16'hFFFF); @(negedge clk);

    // R6: bit-reversed walk with index 8 from 0
    load_ar(3'd0, 16'd8);
    load_ar(3'd3, 16'd0);
    idle(); ptr_ld = 1; ptr_val = 3'd3; cycle();
    begin
      logic [15:0] seq [8] = '{16'd0, 16'd8, 16'd4, 16'd12, 16'd2, 16'd10, 16'd6, 16'd14};
      for (int k = 0; k < 8; k++) begin
        idle(); acc_en = 1; acc_indirect = 1; mod_op = 3'd5; #1;
        check("R6 rc add walk", addr, seq[k]);
        @(negedge clk);
      end
    end
    // R6: reverse-carry subtract from 0 with index 8 gives 0x000F
    load_ar(3'd3, 16'd0);
    ind_acc(3'd6);
    idle(); acc_indirect = 1; #1; check("R6 rc sub", addr, 16'h000F); @(negedge clk);

    // R7: AR0 = 5 current, +index -> 10
    load_ar(3'd0, 16'd5);
    idle(); ptr_ld = 1; ptr_val = 3'd0; cycle();
    ind_acc(3'd3);
    idle(); ar_rd_sel = 3'd0; #1; check("R7 self index", ar_rd_val, 16'd10); @(negedge clk);

    // R10: load and modify same register -> load wins
    idle(); acc_en = 1; acc_indirect = 1; mod_op = 3'd1;
    ar_ld = 1; ar_ld_sel = 3'd0; ar_ld_val = 16'hBEEF; cycle();
    idle(); ar_rd_sel = 3'd0; #1; check("R10 load wins", ar_rd_val, 16'hBEEF); @(negedge clk);

    // R8: address uses old pointer, new pointer after the edge
    load_ar(3'd5, 16'h1234);
    idle(); acc_en = 1; acc_indirect = 1; nxt_ptr_en = 1; nxt_ptr = 3'd5; #1;
    check("R8 old ptr addr", addr, 16'hBEEF); @(posedge clk); m_ptr = 3'd5; @(negedge clk);
    idle(); acc_indirect = 1; #1; check("R8 new ptr addr", addr, 16'h1234); @(negedge clk);

    // R9: immediate load beats a named pointer
    idle(); ptr_ld = 1; ptr_val = 3'd2; acc_en = 1; acc_indirect = 1; nxt_ptr_en = 1;
    nxt_ptr = 3'd6; cycle();
    idle(); #1; check("R9 priority", {13'd0, cur_ptr}, 16'd2); @(negedge clk);

    // R12: modify and pointer requests ignored without indirect access
    load_ar(3'd2, 16'h0777);
    idle(); acc_en = 0; acc_indirect = 1; mod_op = 3'd1; nxt_ptr_en = 1; nxt_ptr = 3'd4; cycle();
    idle(); acc_en = 1; acc_indirect = 0; mod_op = 3'd2; nxt_ptr_en = 1; nxt_ptr = 3'd4; cycle();
    idle(); ar_rd_sel = 3'd2; #1;
    check("R12 reg untouched", ar_rd_val, 16'h0777);
    check("R12 ptr untouched", {13'd0, cur_ptr}, 16'd2);
    @(negedge clk);

    // R5: wrap-around on decrement from 0 and code 7 hold
    load_ar(3'd2, 16'h0000);
    ind_acc(3'd2);
    idle(); ar_rd_sel = 3'd2; #1; check("R5 dec wrap", ar_rd_val, 16'hFFFF); @(negedge clk);
    ind_acc(3'd7);
    idle(); ar_rd_sel = 3'd2; #1; check("R5 code7 hold", ar_rd_val, 16'hFFFF); @(negedge clk);

    // Random mix, all requirements through the model
    for (int n = 0; n < 3000; n++) begin
      idle();
      page_ld      = ($urandom % 10) == 0;
      page_val     = 9'($urandom);
      ptr_ld       = ($urandom % 10) == 0;
      ptr_val      = 3'($urandom);
      acc_en       = ($urandom % 5) != 0;
      acc_indirect = ($urandom % 4) != 0;
      offset       = 7'($urandom);
      mod_op       = 3'($urandom);
      nxt_ptr_en   = ($urandom % 3) == 0;
      nxt_ptr      = 3'($urandom);
      ar_ld        = ($urandom % 7) == 0;
      ar_ld_sel    = 3'($urandom);
      ar_ld_val    = 16'($urandom);
      ar_rd_sel    = 3'($urandom);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule